// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address of every data beat in one memory burst. A mode-register write carries a burst length code and an ordering bit, and the block keeps them. When a start strobe arrives with a start column, the block emits one column address per clock cycle until the burst is complete. Each address comes with a valid flag. A last flag marks the final beat.

Within a burst only the low column bits inside the burst-sized, burst-aligned block change. There are two beat orders. The sequential order counts upward and wraps inside the block. The interleaved order XORs the start offset with the beat index. A start that arrives while the stored length is reserved or not yet programmed raises a one-cycle error and produces no beats.

The control is a three-state machine:
- `ST_IDLE`: no beats are emitted.
- `ST_RUN`: one beat is emitted per cycle.
- `ST_FAULT`: the one-cycle error indication.

Its transitions are:
- **launch**: a start with a usable length, taken from any state into `ST_RUN`.
- **reject**: a start with an unusable length, taken from any state into `ST_FAULT`.
- **step**: `ST_RUN` back to `ST_RUN` while beats remain.
- **finish**: `ST_RUN` to `ST_IDLE` after the last beat, when no start is present.
- **clear**: `ST_FAULT` to `ST_IDLE`.
- **rest**: `ST_IDLE` stays in `ST_IDLE`.

Top module: `burst_colseq`

## Requirements
- R1: After reset `beat_valid`, `beat_last` and `cfg_err` are 0, and no length is programmed.
- R2: A mode write with `mr_bank` equal to 0 stores the length code from `mr_op[2:0]` and the ordering bit from `mr_op[3]`. The length codes are 1 for 2 beats, 2 for 4 beats and 3 for 8 beats. The ordering bit is 0 for sequential and 1 for interleaved. A mode write with any other `mr_bank` value changes nothing.
- R3: A start while the stored length code is unprogrammed or reserved (0, or 4 to 7) drives `cfg_err` high for exactly the next cycle, and no beat follows.
- R4: With a valid length, the first beat appears in the cycle after the start and equals `start_col`. Later beats follow on consecutive cycles.
- R5: In sequential order, beat i carries the low field value (start low + i) modulo the burst length.
- R6: In interleaved order, beat i carries the low field value (start low XOR i).
- R7: Column bits above the burst field always equal those of `start_col`. Nothing carries into them.
- R8: `beat_last` is high on the final beat only. `beat_valid` is low in the following cycle when no start is present.
- R9: A start in the cycle of the last beat launches the next burst with no idle cycle.
- R10: A start during a burst abandons the remaining beats. The new burst begins in the next cycle.
- R11: A burst uses the length and order stored at its start. A mode write during the burst does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mr_wr | input | 1 | Mode-register write strobe |
| mr_bank | input | BANK_W | Bank-select field of the mode write; 0 selects the burst settings |
| mr_op | input | 4 | [2:0] length code, [3] ordering bit |
| start | input | 1 | Burst start strobe |
| start_col | input | COL_W | Start column address |
| col_out | output | COL_W | Column address of the current beat |
| beat_valid | output | 1 | A beat is on `col_out` |
| beat_last | output | 1 | Current beat is the final one |
| cfg_err | output | 1 | Start rejected because the length is unusable |

## Verification
A wrong beat index or a wrong latched length shows on `col_out` or `beat_last` within the burst it affects, at the latest by its final beat. It also shows as a valid beat that the scoreboard has no entry for. A wrong state encoding surfaces one cycle after the start: a beat appears where an error is due, or an error appears with a beat. Every cycle, idle ones included, is compared, so a stray or missing beat is seen in the cycle it occurs.

// File: rtl/burst_colseq_pkg.sv
package burst_colseq_pkg;

    localparam int unsigned OP_W     = 4;
    localparam int unsigned LEN_MSB  = 2;
    localparam int unsigned ORD_BIT  = 3;
    localparam int unsigned IDX_W    = 3;

    typedef enum logic [1:0] {
        LEN_NONE = 2'd0,
        LEN_2    = 2'd1,
        LEN_4    = 2'd2,
        LEN_8    = 2'd3
    } blen_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FAULT = 2'd2
    } seq_state_e;

    function automatic blen_e decode_len(input logic [LEN_MSB:0] code);
        blen_e r;
        case (code)
            3'd1:    r = LEN_2;
            3'd2:    r = LEN_4;
            3'd3:    r = LEN_8;
            default: r = LEN_NONE;
        endcase
        return r;
    endfunction

    function automatic logic [IDX_W-1:0] len_mask(input blen_e l);
        logic [IDX_W-1:0] m;
        case (l)
            LEN_2:   m = 3'd1;
            LEN_4:   m = 3'd3;
            LEN_8:   m = 3'd7;
            default: m = 3'd0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
    import burst_colseq_pkg::*;
#(
    parameter int unsigned BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mr_wr,
    input  logic [BANK_W-1:0] mr_bank,
    input  logic [OP_W-1:0]   mr_op,
    output blen_e             cfg_len,
    output logic              cfg_ilv
);

    logic sel;
    assign sel = mr_wr && (mr_bank == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_len <= LEN_NONE;
            cfg_ilv <= 1'b0;
        end else if (sel) begin
            cfg_len <= decode_len(mr_op[LEN_MSB:0]);
            cfg_ilv <= mr_op[ORD_BIT];
        end
    end

    AST_OTHER_BANK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (mr_wr && mr_bank != '0) |=> ($stable(cfg_len) && $stable(cfg_ilv))); // R2

endmodule

// File: rtl/burst_beat_fsm.sv
module burst_beat_fsm
    import burst_colseq_pkg::*;
#(
    parameter int unsigned COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  blen_e            cfg_len,
    input  logic             cfg_ilv,
    output logic [COL_W-1:0] base_col,
    output blen_e            run_len,
    output logic             run_ilv,
    output logic [IDX_W-1:0] beat_idx,
    output logic             beat_valid,
    output logic             beat_last,
    output logic             cfg_err
);

    seq_state_e       st_q, st_nxt;
    logic [IDX_W-1:0] idx_nxt;
    logic             cfg_ok;

    assign cfg_ok = (cfg_len != LEN_NONE);

    // output process
    always_comb begin
        beat_valid = (st_q == ST_RUN);
        beat_last  = beat_valid && (beat_idx == len_mask(run_len));
        cfg_err    = (st_q == ST_FAULT);
    end

    // next-state process
    always_comb begin
        st_nxt  = st_q;
        idx_nxt = beat_idx;
        unique case (st_q)
            ST_RUN: begin
                if (beat_last) st_nxt = ST_IDLE;          // finish
                else           idx_nxt = beat_idx + 3'd1; // step
            end
            ST_FAULT: st_nxt = ST_IDLE;                   // clear
            ST_IDLE:  st_nxt = ST_IDLE;                   // rest
            default:  st_nxt = ST_IDLE;
        endcase
        if (start) begin
            if (cfg_ok) begin
                st_nxt  = ST_RUN;                         // launch
                idx_nxt = '0;
            end else begin
                st_nxt  = ST_FAULT;                       // reject
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            beat_idx <= '0;
        end else begin
            st_q     <= st_nxt;
            beat_idx <= idx_nxt;
        end
    end

    // burst settings captured at launch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_col <= '0;
            run_len  <= LEN_NONE;
            run_ilv  <= 1'b0;
        end else if (start && cfg_ok) begin
            base_col <= start_col;
            run_len  <= cfg_len;
            run_ilv  <= cfg_ilv;
        end
    end

    AST_IDX_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> (beat_idx <= len_mask(run_len))); // R8
    AST_RUN_HAS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> (run_len != LEN_NONE)); // R3
    AST_SETTINGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !start) |=> ($stable(run_len) && $stable(run_ilv))); // R11

endmodule

// File: rtl/burst_col_former.sv
module burst_col_former
    import burst_colseq_pkg::*;
#(
    parameter int unsigned COL_W = 10
) (
    input  logic [COL_W-1:0] base_col,
    input  blen_e            run_len,
    input  logic             run_ilv,
    input  logic [IDX_W-1:0] beat_idx,
    output logic [COL_W-1:0] col_addr
);

    localparam int unsigned HI_W = COL_W - IDX_W;

    logic [IDX_W-1:0] mask, lo_base, lo_step, lo_out;

    always_comb begin
        mask    = len_mask(run_len);
        lo_base = base_col[IDX_W-1:0];
        if (run_ilv) lo_step = lo_base ^ beat_idx;
        else         lo_step = lo_base + beat_idx;
        lo_out  = (lo_base & ~mask) | (lo_step & mask);
    end

    generate
        if (HI_W > 0) begin : g_hi
            assign col_addr = {base_col[COL_W-1:IDX_W], lo_out};
        end else begin : g_lo
            assign col_addr = lo_out[COL_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/burst_colseq.sv
module burst_colseq
    import burst_colseq_pkg::*;
#(
    parameter int unsigned COL_W  = 10,
    parameter int unsigned BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mr_wr,
    input  logic [BANK_W-1:0] mr_bank,
    input  logic [OP_W-1:0]   mr_op,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    output logic [COL_W-1:0]  col_out,
    output logic              beat_valid,
    output logic              beat_last,
    output logic              cfg_err
);

    blen_e            cfg_len, run_len;
    logic             cfg_ilv, run_ilv;
    logic [COL_W-1:0] base_col;
    logic [IDX_W-1:0] beat_idx;

    burst_mode_reg #(.BANK_W(BANK_W)) u_mode (
        .clk(clk), .rst_n(rst_n), .mr_wr(mr_wr), .mr_bank(mr_bank),
        .mr_op(mr_op), .cfg_len(cfg_len), .cfg_ilv(cfg_ilv)
    );

    burst_beat_fsm #(.COL_W(COL_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
        .cfg_len(cfg_len), .cfg_ilv(cfg_ilv), .base_col(base_col),
        .run_len(run_len), .run_ilv(run_ilv), .beat_idx(beat_idx),
        .beat_valid(beat_valid), .beat_last(beat_last), .cfg_err(cfg_err)
    );

    burst_col_former #(.COL_W(COL_W)) u_form (
        .base_col(base_col), .run_len(run_len), .run_ilv(run_ilv),
        .beat_idx(beat_idx), .col_addr(col_out)
    );

    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |-> beat_valid); // R8
    AST_ERR_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !beat_valid); // R3
    AST_BAD_START_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (start && cfg_len == LEN_NONE) |=> (cfg_err && !beat_valid)); // R3
    AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (start && cfg_len != LEN_NONE) |=> (beat_valid && col_out == $past(start_col))); // R4
    AST_DROP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_last && !start) |=> !beat_valid); // R8
    AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !start) |=> (!beat_valid || $stable(col_out[COL_W-1:IDX_W]))); // R7

endmodule

// File: tb/burst_colseq_bench.sv
module burst_colseq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int COL_W = 10;

    typedef struct {
        int               cyc;
        bit               v;
        logic [COL_W-1:0] col;
        bit               last;
        bit               err;
        string            tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mr_wr = 1'b0;
    logic [1:0]       mr_bank = '0;
    logic [3:0]       mr_op = '0;
    logic             start = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic [COL_W-1:0] col_out;
    logic             beat_valid, beat_last, cfg_err;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   mon_on = 0;
    bit   done = 0;
    int   tb_len = 0;
    bit   tb_ilv = 0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc++;

    burst_colseq #(.COL_W(COL_W), .BANK_W(2)) u_burst_colseq (
        .clk(clk), .rst_n(rst_n), .mr_wr(mr_wr), .mr_bank(mr_bank), .mr_op(mr_op),
        .start(start), .start_col(start_col), .col_out(col_out),
        .beat_valid(beat_valid), .beat_last(beat_last), .cfg_err(cfg_err)
    );

    function automatic logic [COL_W-1:0] exp_col(logic [COL_W-1:0] b, int i, int len, bit ilv);
        logic [COL_W-1:0] lo, m;
        m  = COL_W'(len - 1);
        lo = ilv ? (b ^ COL_W'(i)) : (b + COL_W'(i));
        return (b & ~m) | (lo & m);
    endfunction

    task automatic mode_write(input logic [1:0] bank, input logic [3:0] op);
        @(negedge clk);
        mr_wr = 1'b1; mr_bank = bank; mr_op = op;
        if (bank == 2'd0) begin
            case (op[2:0])
                3'd1: tb_len = 2;
                3'd2: tb_len = 4;
                3'd3: tb_len = 8;
                default: tb_len = 0;
            endcase
            tb_ilv = op[3];
        end
        @(negedge clk);
        mr_wr = 1'b0;
    endtask

    // driver: pushes the expected beats of one start
    task automatic fire(input logic [COL_W-1:0] col, input string tag);
        exp_t e;
        @(negedge clk);
        while (q.size() > 0 && q[$].cyc >= cyc + 1) void'(q.pop_back());
        start = 1'b1; start_col = col;
        if (tb_len == 0) begin
            e.cyc = cyc + 1; e.v = 0; e.col = '0; e.last = 0; e.err = 1; e.tag = tag;
            q.push_back(e);
        end else begin
            for (int i = 0; i < tb_len; i++) begin
                e.cyc = cyc + 1 + i; e.v = 1; e.col = exp_col(col, i, tb_len, tb_ilv);
                e.last = (i == tb_len - 1); e.err = 0; e.tag = tag;
                q.push_back(e);
            end
        end
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compares every cycle against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (mon_on) begin
                exp_t e;
                if (q.size() > 0 && q[0].cyc == cyc) begin
                    e = q.pop_front();
                end else begin
                    e.cyc = cyc; e.v = 0; e.col = '0; e.last = 0; e.err = 0; e.tag = "R8 idle";
                end
                n_chk++;
                if (beat_valid !== e.v || beat_last !== e.last || cfg_err !== e.err ||
                    (e.v && col_out !== e.col)) begin
                    n_bad++;
                    $display("FAIL %s cyc %0d: valid/last/err/col = %0b/%0b/%0b/%h, expected %0b/%0b/%0b/%h",
                             e.tag, cyc, beat_valid, beat_last, cfg_err, col_out,
                             e.v, e.last, e.err, e.col);
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not finish, actual hung, expected done");
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        idle(3);
        n_chk++;
        if (beat_valid !== 1'b0 || beat_last !== 1'b0 || cfg_err !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset: valid/last/err = %0b/%0b/%0b, expected 0/0/0",
                     beat_valid, beat_last, cfg_err);
        end
        rst_n = 1'b1;
        mon_on = 1;
        idle(2);

        fire(10'h005, "R1 unprogrammed start");     idle(3);
        mode_write(2'd0, 4'b0001);
        fire(10'h005, "R5 seq len2");                idle(4);
        mode_write(2'd0, 4'b0010);
        fire(10'h00E, "R5 seq len4");                idle(6);
        mode_write(2'd0, 4'b0011);
        fire(10'h3FD, "R7 seq len8 no carry");       idle(10);
        mode_write(2'd0, 4'b1011);
        fire(10'h02B, "R6 ilv len8");                idle(10);
        mode_write(2'd0, 4'b1010);
        fire(10'h001, "R6 ilv len4");                idle(6);
        mode_write(2'd0, 4'b1001);
        fire(10'h3FE, "R6 ilv len2");                idle(4);

        mode_write(2'd0, 4'b0010);
        mode_write(2'd2, 4'b1011);
        fire(10'h123, "R2 other bank ignored");      idle(6);

        fire(10'h046, "R9 first burst");
        idle(2);
        fire(10'h0A1, "R9 back-to-back");            idle(6);

        mode_write(2'd0, 4'b0011);
        fire(10'h200, "R10 abandoned burst");
        fire(10'h317, "R10 new burst");              idle(10);

        mode_write(2'd0, 4'b0010);
        fire(10'h10B, "R11 burst keeps settings");
        mode_write(2'd0, 4'b1011);
        idle(6);
        fire(10'h10B, "R11 new settings");           idle(10);

        mode_write(2'd0, 4'b0100);
        fire(10'h011, "R3 reserved code 4");         idle(3);
        mode_write(2'd0, 4'b0000);
        fire(10'h011, "R3 reserved code 0");         idle(3);
        mode_write(2'd0, 4'b0011);
        fire(10'h050, "R4 start");
        mode_write(2'd0, 4'b0111);
        fire(10'h060, "R3 bad start aborts burst");  idle(12);

        done = 1;
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule